// File: doc/BRIEF.md
# Priority Ready Table

This block keeps one presence bit for each of 64 task priorities and reports which of them is the most urgent. The bits sit in an 8x8 array: the upper three bits of a priority pick the row, the lower three bits pick the bit inside that row. Priority 0 is the most urgent. A lower number always beats a higher one, so priority 1 outranks priorities 6 and 7.

A scheduler sets an entry when a task becomes runnable and clears it when the task blocks or is removed. Each cycle it reads the most urgent occupied priority from a combinational two-level encoder. The encoder first finds the lowest-numbered nonempty row, then the lowest set bit inside that row. A second combinational port answers whether a given priority is present. A second copy of the same block can serve as a waiting list.

Top module: `prio_ready_table`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every entry is emptied. After reset, `top_valid` is 0, `top_prio` is 0 and `q_hit` is 0 for every query priority.
- R2: A high `flush` at a rising edge empties every entry. It takes precedence over `wr_set` and `wr_clr` in the same cycle.
- R3: A high `wr_set` with `wr_clr` low sets the entry for `wr_prio`. Bits [5:3] of `wr_prio` select the row and bits [2:0] select the bit, so entry number = row*8 + bit. The entry is visible on the read ports from the cycle after the edge.
- R4: A high `wr_clr` empties the entry for `wr_prio`. It is visible from the cycle after the edge.
- R5: Setting an entry that is already set, or clearing one that is already empty, leaves all 64 entries unchanged.
- R6: When `wr_set` and `wr_clr` are both high in the same cycle, the clear wins and the entry ends up empty.
- R7: While any entry is set, `top_valid` is 1 and `top_prio` equals the numerically smallest set priority.
- R8: While no entry is set, `top_valid` is 0 and `top_prio` is 0.
- R9: `q_hit` is combinationally 1 exactly when the entry for `q_prio` is set.
- R10: A write or an idle cycle changes no entry other than the one that `wr_prio` addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Synchronous empty-all command |
| wr_set | input | 1 | Set the addressed entry |
| wr_clr | input | 1 | Clear the addressed entry |
| wr_prio | input | 6 | Priority addressed by a write |
| q_prio | input | 6 | Priority for the membership query |
| q_hit | output | 1 | Queried entry is set |
| top_prio | output | 6 | Most urgent set priority (0 when empty) |
| top_valid | output | 1 | At least one entry is set |

## Verification
Every write and flush lands in the table at the rising edge where it is sampled. Both read ports are combinational from the table, so a write's effect is due one edge after it is driven and no earlier. The bench drives commands on the falling edge and then lets exactly one rising edge pass. It idles the write inputs and only then compares `top_prio`, `top_valid`, and `q_hit` for all 64 query values against a 64-bit model. Since `q_hit` has no latency, each query is checked a fraction of a nanosecond after `q_prio` changes.

// File: rtl/prt_pkg.sv
package prt_pkg;
    // Per-row command resolved from the top-level write inputs.
    typedef enum logic [1:0] {
        ROW_IDLE  = 2'd0,
        ROW_SET   = 2'd1,
        ROW_CLR   = 2'd2,
        ROW_FLUSH = 2'd3
    } row_cmd_e;
endpackage

// File: rtl/prt_first_set.sv
// prt_first_set: finds the lowest-index set bit of a vector.
// Assumes W is a power of two, at least 2. idx is 0 when no bit is set.
module prt_first_set #(
    parameter int W  = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top so that the lowest set index is written last.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    // Flag that at least one bit is set.
    assign any = |vec;

    always_comb begin
        assert_lowest_wins_R7: assert (!any || (vec[idx] && ((vec & ((W'(1) << idx) - W'(1))) == '0)))
            else $error("first-set index not the lowest set bit");
    end
endmodule

// File: rtl/prt_row.sv
// prt_row: one row of presence bits, updated by a pre-resolved command.
// Assumes the top has already qualified cmd for this row. Flush is broadcast.
module prt_row
    import prt_pkg::*;
#(
    parameter int ROW_W = 8,
    localparam int SW   = $clog2(ROW_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  row_cmd_e         cmd,
    input  logic [SW-1:0]    bit_sel,
    output logic [ROW_W-1:0] bits_q
);
    // Storage update: reset and flush empty the row, set/clear touch one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            case (cmd)
                ROW_FLUSH: bits_q <= '0;
                ROW_SET:   bits_q[bit_sel] <= 1'b1;
                ROW_CLR:   bits_q[bit_sel] <= 1'b0;
                default:   bits_q <= bits_q;
            endcase
        end
    end

    assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == ROW_SET) |=> bits_q[$past(bit_sel)]);
    assert_clear_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == ROW_CLR) |=> !bits_q[$past(bit_sel)]);
    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == ROW_IDLE) |=> $stable(bits_q));
    assert_flush_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == ROW_FLUSH) |=> (bits_q == '0));
endmodule

// File: rtl/prio_ready_table.sv
// prio_ready_table: 2^(GRP_BITS+BIT_BITS) presence bits in a row/bit array.
// Provides a two-level lowest-priority encoder and a membership query.
// Assumes one clock and a synchronous active-low reset. Reads are combinational
// from the registered table, so a write shows on the outputs one edge later.
module prio_ready_table
    import prt_pkg::*;
#(
    parameter int GRP_BITS = 3,
    parameter int BIT_BITS = 3,
    localparam int PRIO_W   = GRP_BITS + BIT_BITS,
    localparam int NUM_ROWS = 1 << GRP_BITS,
    localparam int ROW_W    = 1 << BIT_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [PRIO_W-1:0] wr_prio,
    input  logic [PRIO_W-1:0] q_prio,
    output logic              q_hit,
    output logic [PRIO_W-1:0] top_prio,
    output logic              top_valid
);
    logic [GRP_BITS-1:0] wr_grp;
    logic [BIT_BITS-1:0] wr_bit;
    logic [ROW_W-1:0]    row_q   [NUM_ROWS];
    logic [NUM_ROWS-1:0] row_any;
    logic [GRP_BITS-1:0] top_grp;
    logic [BIT_BITS-1:0] top_bit;
    logic [ROW_W-1:0]    top_row;
    logic                grp_any;
    logic                bit_any;

    // Split the write priority into row and bit selects.
    assign wr_grp = wr_prio[PRIO_W-1:BIT_BITS];
    assign wr_bit = wr_prio[BIT_BITS-1:0];

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        row_cmd_e cmd;

        // Resolve the command for this row: flush, then clear, then set.
        always_comb begin
            if (flush)                                         cmd = ROW_FLUSH;
            else if (wr_grp == GRP_BITS'(r) && wr_clr)         cmd = ROW_CLR;
            else if (wr_grp == GRP_BITS'(r) && wr_set)         cmd = ROW_SET;
            else                                               cmd = ROW_IDLE;
        end

        prt_row #(.ROW_W(ROW_W)) u_row (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd     (cmd),
            .bit_sel (wr_bit),
            .bits_q  (row_q[r])
        );

        // Row summary used by the first encoder level.
        assign row_any[r] = |row_q[r];
    end

    // Level one: lowest nonempty row.
    prt_first_set #(.W(NUM_ROWS)) u_grp_enc (
        .vec (row_any),
        .idx (top_grp),
        .any (grp_any)
    );

    // Pick the winning row for the second level.
    assign top_row = row_q[top_grp];

    // Level two: lowest set bit inside the winning row.
    prt_first_set #(.W(ROW_W)) u_bit_enc (
        .vec (top_row),
        .idx (top_bit),
        .any (bit_any)
    );

    // Combine the two levels into the reported priority.
    assign top_prio  = {top_grp, top_bit};
    assign top_valid = grp_any;

    // Membership lookup by row and bit of the query.
    assign q_hit = row_q[q_prio[PRIO_W-1:BIT_BITS]][q_prio[BIT_BITS-1:0]];

    assert_top_is_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> (row_q[top_grp][top_bit] && bit_any));
    assert_no_urgent_row_above_R7: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> ((row_any & ((NUM_ROWS'(1) << top_grp) - NUM_ROWS'(1))) == '0));
    assert_empty_reports_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !top_valid |-> (top_prio == '0));
    assert_flush_clears_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !top_valid);
    assert_clear_beats_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && wr_clr && !flush) |=> !row_q[$past(wr_grp)][$past(wr_bit)]);
endmodule

// File: tb/sim_prio_ready_table.sv
`timescale 1ns/1ps
module sim_prio_ready_table;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic       wr_set = 1'b0;
    logic       wr_clr = 1'b0;
    logic [5:0] wr_prio = '0;
    logic [5:0] q_prio = '0;
    logic       q_hit;
    logic [5:0] top_prio;
    logic       top_valid;

    logic [63:0] model = '0;
    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    prio_ready_table u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_set(wr_set), .wr_clr(wr_clr),
        .wr_prio(wr_prio), .q_prio(q_prio), .q_hit(q_hit),
        .top_prio(top_prio), .top_valid(top_valid)
    );

    // Apply one command for one edge, update the model, leave inputs idle.
    task automatic do_op(input bit s, input bit c, input bit f, input int p);
        @(negedge clk);
        wr_set = s; wr_clr = c; flush = f; wr_prio = 6'(p);
        if (f) model = '0;
        else if (c) model[p] = 1'b0;
        else if (s) model[p] = 1'b1;
        @(posedge clk);
        #1;
        wr_set = 0; wr_clr = 0; flush = 0;
    endtask

    // Compare both read ports against the model; tag names the requirement.
    task automatic check_all(input string tag);
        int exp_p;
        bit exp_v;
        exp_p = 0; exp_v = 0;
        for (int i = 63; i >= 0; i--) if (model[i]) begin exp_p = i; exp_v = 1; end
        vectors++;
        if (top_valid !== exp_v || top_prio !== 6'(exp_p)) begin
            fails++;
            $display("FAIL %s top: actual valid=%0b prio=%0d expected valid=%0b prio=%0d",
                     tag, top_valid, top_prio, exp_v, exp_p);
        end
        for (int q = 0; q < 64; q++) begin
            q_prio = 6'(q);
            #0.02;
            vectors++;
            if (q_hit !== model[q]) begin
                fails++;
                $display("FAIL %s R9 q_hit[%0d]: actual %0b expected %0b", tag, q, q_hit, model[q]);
            end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        // R1: reset with stray write inputs must still leave an empty table
        @(negedge clk); wr_set = 1; wr_prio = 6'd9;
        @(posedge clk); #1; wr_set = 0;
        @(negedge clk); rst_n = 1;
        check_all("R1 R8 reset");

        // R3 R7: 7, 1, 6 in turn; 1 must win once present
        do_op(1,0,0,7); check_all("R3 R7 set 7");
        do_op(1,0,0,1); check_all("R3 R7 set 1");
        do_op(1,0,0,6); check_all("R3 R7 set 6");
        do_op(0,1,0,1); check_all("R4 R7 clear 1");

        // R5: idempotent writes
        do_op(1,0,0,6); check_all("R5 set again");
        do_op(0,1,0,33); check_all("R5 clear empty");

        // R6: clear wins over set on the same entry
        do_op(1,1,0,6); check_all("R6 set+clear set entry");
        do_op(1,1,0,40); check_all("R6 set+clear empty entry");

        // R2: flush overrides a concurrent set
        do_op(1,0,0,20);
        do_op(1,0,1,3); check_all("R2 flush with set");

        // R3 R4 R10: each entry alone
        for (int p = 0; p < 64; p++) begin
            do_op(1,0,0,p); check_all("R3 R10 single set");
            do_op(0,1,0,p); check_all("R4 R8 single clear");
        end
        // R7: fill from the least urgent upward, winner moves down each step
        for (int p = 63; p >= 0; p--) begin
            do_op(1,0,0,p); check_all("R7 fill descending");
        end
        // R7 R8: drain from the most urgent, winner moves up each step
        for (int p = 0; p < 64; p++) begin
            do_op(0,1,0,p); check_all("R7 R8 drain ascending");
        end
        // R3 R4 R5 R6 R10: pseudo-random mixed commands
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_op(lfsr[7], lfsr[8] & lfsr[9], (lfsr[11:6] == 6'd0), int'(lfsr[5:0]));
            check_all("R10 mixed");
        end
        // R2: flush a partly full table
        do_op(0,0,1,0); check_all("R2 final flush");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule